// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting channel of a programmable interval timer. It shares a small register bus with its sibling channels. Two address bits pick one of three counters or the control register, and separate read and write strobes move bytes over an 8-bit data path. Each channel has its own count enable, gate input and output pin. A full three-channel timer is built from three instances, each with its own channel number, with their read data ORed together.

A control word picks the channel it is aimed at, how the 16-bit count is moved as bytes, and one of six output behaviours. The behaviours are: an interrupt at terminal count, a retriggerable one-shot, a rate generator, a square wave, a software-started strobe and a gate-started strobe. The bus can also latch a snapshot of the running count, so that software reads a coherent value while the counter keeps going. The counter advances only on cycles where the count-enable input is high, so the timebase can be any divided rate of the system clock. Counting is always binary. The decimal-select bit is accepted but has no effect.

Top module: `pit_channel`

## Requirements
- R1: Control words are written at address 3, and a channel accepts one only when its bits [7:6] equal the channel number (CHAN_ID). A word with 11 in those bits, a word naming another channel, and any count write to another counter's address leave the channel's output and count unchanged.
- R2: The control word fields are as follows. Bits [5:4] give the access order: 00 latch command, 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits [3:1] give the mode: 000 mode 0, 001 mode 1, x10 mode 2, x11 mode 3, 100 mode 4, 101 mode 5. Bit 0 is ignored. After a control word the output is low in modes 0 and 5 and high in every other mode.
- R3: A low-only write clears the high byte, and a high-only write clears the low byte. In low-then-high order, the first byte alone does not change the count. A completed count is loaded on the first count-enable cycle after its last byte.
- R4: A counter read returns the count bytes in the selected access order. A latch command freezes the count for reading until the single selected byte, or both bytes, have been read. A further latch command while a value is held is ignored.
- R5: In mode 0 the output goes high n enabled cycles after the load cycle. It then stays high until a new count or control word arrives.
- R6: In modes 0, 2, 3 and 4 a low gate holds the count.
- R7: In mode 1 a rising gate edge arms a trigger. The next enabled cycle loads the count and drives the output low, and the output returns high n cycles later. A new trigger restarts the interval.
- R8: In mode 2 the output has a period of n enabled cycles and is low for exactly one of them. The count reloads by itself.
- R9: In mode 3 the output is a square wave of period n. It is high for ceil(n/2) enabled cycles and low for floor(n/2).
- R10: In mode 4 the output is high. It goes low for exactly one enabled cycle, n cycles after the load cycle, and does not repeat unless a new count is written.
- R11: In mode 5 the output stays low until a rising gate edge. The next enabled cycle loads the count and drives the output high. The output then goes low for one cycle n cycles later and returns high.
- R12: After reset the output is low, the mode is 0, the access order is low then high, and the count reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 2 | Counter select (0 to 2) or control register (3) |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, zero when this counter is not read |
| cnt_ce | input | 1 | Count enable, the counter timebase |
| gate_in | input | 1 | Gate: count enable or trigger, depending on mode |
| tmr_out | output | 1 | Counter output |

## Verification
The bench targets the reload edges. These are the one-cycle low of the rate generator, which a design with an off-by-one counter would widen or shift by a cycle, and the odd-count square wave, where a wrong split would make the two phases equal or swap the long phase. It holds a latched value across further counting and sends a second latch command, so that a latch that was overwritten or released early would return live bytes. It also writes only the first of two bytes, writes through another counter's address and sends another channel's control word, so a channel that loaded early or decoded too loosely would show a changed count or output. Retriggering mid-interval in mode 1 and pulsing the gate in mode 5 show whether the count is reloaded on each edge.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [2:0] {
      MD_TC_INT    = 3'd0,
      MD_ONESHOT   = 3'd1,
      MD_RATE      = 3'd2,
      MD_SQUARE    = 3'd3,
      MD_SW_STROBE = 3'd4,
      MD_HW_STROBE = 3'd5
   } pit_mode_e;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'd0,
      ACC_LO    = 2'd1,
      ACC_HI    = 2'd2,
      ACC_LOHI  = 2'd3
   } pit_acc_e;

   // Mode field: a set middle bit folds the two periodic modes onto 2 and 3
   function automatic pit_mode_e decode_mode(input logic [2:0] f);
      if (f[1]) return f[0] ? MD_SQUARE : MD_RATE;
      return pit_mode_e'(f);
   endfunction

   // Output level right after a control word is accepted
   function automatic logic out_after_ctl(input pit_mode_e m);
      return !(m == MD_TC_INT || m == MD_HW_STROBE);
   endfunction

endpackage

// File: rtl/pit_ctrl_reg.sv
module pit_ctrl_reg
   import pit_pkg::*;
#(
   parameter int ADDR_W  = 2,
   parameter int CW_W    = 7,
   parameter int CHAN_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CW_W-1:0]   cw,
   output pit_mode_e         mode_q,
   output pit_mode_e         new_mode,
   output pit_acc_e          acc_q,
   output logic              ctl_load,
   output logic              latch_cmd
);
   localparam logic [ADDR_W-1:0] CTL_ADDR = '1;
   localparam logic [1:0]        MY_SC    = 2'(CHAN_ID);

   logic     ctl_hit;
   logic     sc_match;
   pit_acc_e acc_f;

   assign ctl_hit  = wr_en && (addr == CTL_ADDR);
   assign sc_match = (cw[CW_W-1 -: 2] == MY_SC);
   assign acc_f    = pit_acc_e'(cw[4:3]);
   assign new_mode = decode_mode(cw[2:0]);

   assign ctl_load  = ctl_hit && sc_match && (acc_f != ACC_LATCH);
   assign latch_cmd = ctl_hit && sc_match && (acc_f == ACC_LATCH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MD_TC_INT;
         acc_q  <= ACC_LOHI;
      end else if (ctl_load) begin
         mode_q <= new_mode;
         acc_q  <= acc_f;
      end
   end

   // R2
   acc_never_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_load |=> (acc_q != ACC_LATCH));

endmodule

// File: rtl/pit_io_seq.sv
module pit_io_seq
   import pit_pkg::*;
#(
   parameter int ADDR_W  = 2,
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 16,
   parameter int CHAN_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  pit_acc_e          acc_q,
   input  logic              ctl_load,
   input  logic              latch_cmd,
   input  logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  init_q,
   output logic              wr_done_q,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CHAN_ID);

   logic              wr_hit, rd_hit;
   logic              wr_hi_q, rd_hi_q;
   logic              latch_vld_q;
   logic [CNT_W-1:0]  latch_q;
   logic [CNT_W-1:0]  src;
   logic [DATA_W-1:0] sel_byte;

   assign wr_hit = wr_en && (addr == MY_ADDR);
   assign rd_hit = rd_en && (addr == MY_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q      <= '0;
         wr_done_q   <= 1'b0;
         wr_hi_q     <= 1'b0;
         rd_hi_q     <= 1'b0;
         latch_vld_q <= 1'b0;
         latch_q     <= '0;
      end else begin
         wr_done_q <= 1'b0;
         if (ctl_load) begin
            wr_hi_q     <= 1'b0;
            rd_hi_q     <= 1'b0;
            latch_vld_q <= 1'b0;
         end else begin
            if (wr_hit) begin
               case (acc_q)
                  ACC_LO: begin
                     init_q    <= {{DATA_W{1'b0}}, wdata};
                     wr_done_q <= 1'b1;
                  end
                  ACC_HI: begin
                     init_q    <= {wdata, {DATA_W{1'b0}}};
                     wr_done_q <= 1'b1;
                  end
                  default: begin
                     if (!wr_hi_q) begin
                        init_q[DATA_W-1:0] <= wdata;
                        wr_hi_q            <= 1'b1;
                     end else begin
                        init_q[CNT_W-1:DATA_W] <= wdata;
                        wr_hi_q                <= 1'b0;
                        wr_done_q              <= 1'b1;
                     end
                  end
               endcase
            end
            if (latch_cmd && !latch_vld_q) begin
               latch_q     <= cnt;
               latch_vld_q <= 1'b1;
            end
            if (rd_hit) begin
               if (acc_q == ACC_LOHI) begin
                  rd_hi_q <= !rd_hi_q;
                  if (rd_hi_q) latch_vld_q <= 1'b0;
               end else begin
                  latch_vld_q <= 1'b0;
               end
            end
         end
      end
   end

   always_comb begin
      src = latch_vld_q ? latch_q : cnt;
      case (acc_q)
         ACC_LO:  sel_byte = src[DATA_W-1:0];
         ACC_HI:  sel_byte = src[CNT_W-1:DATA_W];
         default: sel_byte = rd_hi_q ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];
      endcase
      rdata = rd_hit ? sel_byte : '0;
   end

   // R4
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_vld_q && !rd_hit && !ctl_load) |=> (latch_vld_q && $stable(latch_q)));

   // R3
   first_byte_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && acc_q == ACC_LOHI && !wr_hi_q && !ctl_load) |=> !wr_done_q);

endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
   import pit_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int GATE_SYNC = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             gate,
   input  pit_mode_e        mode_q,
   input  pit_mode_e        new_mode,
   input  logic             ctl_load,
   input  logic             wr_done,
   input  logic [CNT_W-1:0] init,
   output logic             out_q,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   logic gate_s, gate_d, gate_rise;
   logic running, load_pend, trig, have_cnt, strb;
   logic trig_mode;

   logic [CNT_W-1:0] dec, step_cnt;
   logic             step_out, step_run, step_strb;

   generate
      if (GATE_SYNC == 0) begin : g_gate_direct
         assign gate_s = gate;
      end else begin : g_gate_sync
         logic [GATE_SYNC-1:0] sh;
         always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= (sh << 1) | GATE_SYNC'(gate);
         end
         assign gate_s = sh[GATE_SYNC-1];
      end
   endgenerate

   assign gate_rise = gate_s && !gate_d;
   assign trig_mode = (mode_q == MD_ONESHOT) || (mode_q == MD_HW_STROBE);

   // One counting step of the current mode
   always_comb begin
      dec       = cnt_q - ONE;
      step_cnt  = dec;
      step_out  = out_q;
      step_run  = 1'b1;
      step_strb = 1'b0;
      case (mode_q)
         MD_TC_INT, MD_ONESHOT: begin
            if (cnt_q == ONE) step_out = 1'b1;
         end
         MD_RATE: begin
            if (cnt_q == ONE) begin
               step_cnt = init;
               step_out = 1'b1;
            end else if (cnt_q == TWO) begin
               step_out = 1'b0;
            end
         end
         MD_SQUARE: begin
            step_cnt = (cnt_q == ONE) ? init : dec;
            step_out = (step_cnt > (init >> 1));
         end
         default: begin
            if (cnt_q == ONE) begin
               step_out  = 1'b0;
               step_run  = 1'b0;
               step_strb = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q     <= 1'b0;
         cnt_q     <= '0;
         gate_d    <= 1'b0;
         running   <= 1'b0;
         load_pend <= 1'b0;
         trig      <= 1'b0;
         have_cnt  <= 1'b0;
         strb      <= 1'b0;
      end else begin
         gate_d <= gate_s;
         if (ctl_load) begin
            out_q     <= out_after_ctl(new_mode);
            running   <= 1'b0;
            load_pend <= 1'b0;
            trig      <= 1'b0;
            have_cnt  <= 1'b0;
            strb      <= 1'b0;
         end else begin
            if (gate_rise)  trig <= 1'b1;
            else if (tick)  trig <= 1'b0;

            if (wr_done) begin
               load_pend <= 1'b1;
               have_cnt  <= 1'b1;
               if (mode_q == MD_TC_INT) out_q <= 1'b0;
            end else if (tick && !trig_mode) begin
               load_pend <= 1'b0;
            end

            if (tick) begin
               if (strb) begin
                  out_q <= 1'b1;
                  strb  <= 1'b0;
               end
               if (trig_mode) begin
                  if (trig && have_cnt) begin
                     cnt_q   <= init;
                     running <= 1'b1;
                     out_q   <= (mode_q != MD_ONESHOT);
                     strb    <= 1'b0;
                  end else if (running) begin
                     cnt_q   <= step_cnt;
                     out_q   <= step_out;
                     running <= step_run;
                     strb    <= step_strb;
                  end
               end else if (load_pend) begin
                  cnt_q   <= init;
                  running <= 1'b1;
                  if (mode_q != MD_TC_INT) out_q <= 1'b1;
               end else if (running && gate_s) begin
                  cnt_q   <= step_cnt;
                  out_q   <= step_out;
                  running <= step_run;
                  strb    <= step_strb;
               end
            end
         end
      end
   end

   // R2
   ctl_out_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_load |=> (out_q == out_after_ctl($past(new_mode))));

   // R6
   gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_load && !trig_mode && !gate_s && !load_pend) |=> $stable(cnt_q));

   // R5
   tc_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_TC_INT && out_q && !ctl_load && !wr_done) |=> out_q);

   // R8
   rate_low_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_RATE && tick && gate_s && !out_q && !ctl_load) |=> out_q);

   // R10
   strobe_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_SW_STROBE && tick && !out_q && !ctl_load) |=> out_q);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 16,
   parameter int CHAN_ID   = 0,
   parameter int GATE_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cnt_ce,
   input  logic              gate_in,
   output logic              tmr_out
);
   localparam int CW_W = DATA_W - 1;

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("pit_channel: control word layout needs an 8-bit data bus");
      end
      if (CNT_W != 2 * DATA_W) begin : g_bad_cnt_w
         $error("pit_channel: count must be exactly two data bytes");
      end
      if (ADDR_W != 2) begin : g_bad_addr_w
         $error("pit_channel: three counters plus control need two address bits");
      end
      if (CHAN_ID < 0 || CHAN_ID > 2) begin : g_bad_chan
         $error("pit_channel: channel number must be 0, 1 or 2");
      end
      if (GATE_SYNC < 0 || GATE_SYNC > 4) begin : g_bad_sync
         $error("pit_channel: gate synchronizer depth out of range");
      end
   endgenerate

   pit_mode_e        mode_q, new_mode;
   pit_acc_e         acc_q;
   logic             ctl_load, latch_cmd, wr_done;
   logic [CNT_W-1:0] init, cnt;

   pit_ctrl_reg #(
      .ADDR_W (ADDR_W),
      .CW_W   (CW_W),
      .CHAN_ID(CHAN_ID)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .cw       (bus_wdata[DATA_W-1:1]),
      .mode_q   (mode_q),
      .new_mode (new_mode),
      .acc_q    (acc_q),
      .ctl_load (ctl_load),
      .latch_cmd(latch_cmd)
   );

   pit_io_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .CHAN_ID(CHAN_ID)
   ) u_io (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .rd_en    (bus_rd),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .acc_q    (acc_q),
      .ctl_load (ctl_load),
      .latch_cmd(latch_cmd),
      .cnt      (cnt),
      .init_q   (init),
      .wr_done_q(wr_done),
      .rdata    (bus_rdata)
   );

   pit_count_core #(
      .CNT_W    (CNT_W),
      .GATE_SYNC(GATE_SYNC)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (cnt_ce),
      .gate    (gate_in),
      .mode_q  (mode_q),
      .new_mode(new_mode),
      .ctl_load(ctl_load),
      .wr_done (wr_done),
      .init    (init),
      .out_q   (tmr_out),
      .cnt_q   (cnt)
   );

endmodule

// File: tb/pit_channel_test.sv
module pit_channel_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       cnt_ce = 1'b0;
   logic       gate_in = 1'b0;
   logic       tmr_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pit_channel uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .cnt_ce   (cnt_ce),
      .gate_in  (gate_in),
      .tmr_out  (tmr_out)
   );

   // expected output after k ticks past the load tick
   function automatic logic exp_rate(input int k, input int n);
      return (k % n) != (n - 1);
   endfunction

   function automatic logic exp_square(input int k, input int n);
      return (n - (k % n)) > (n / 2);
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd16(output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(2'd0, lo);
      rd(2'd0, hi);
      v = {hi, lo};
   endtask

   task automatic tick();
      @(negedge clk);
      cnt_ce = 1'b1;
      @(negedge clk);
      cnt_ce = 1'b0;
   endtask

   task automatic tickn(input int n);
      repeat (n) tick();
   endtask

   task automatic gate_pulse();
      @(negedge clk); gate_in = 1'b0;
      @(negedge clk); gate_in = 1'b1;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  b;
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      check("R12 out after reset", {15'd0, tmr_out}, 16'd0);
      rd16(v);
      check("R12 count after reset", v, 16'h0000);

      // R5 mode 0, n=5
      gate_in = 1'b1;
      wr(2'd3, 8'h30);
      check("R2 mode0 out low after control", {15'd0, tmr_out}, 16'd0);
      wr(2'd0, 8'd5); wr(2'd0, 8'd0);
      tick();
      tickn(4);
      check("R5 out still low before terminal", {15'd0, tmr_out}, 16'd0);
      rd16(v);
      check("R4 live count read lo/hi", v, 16'd1);
      tick();
      check("R5 out high at terminal", {15'd0, tmr_out}, 16'd1);
      tickn(3);
      check("R5 out stays high", {15'd0, tmr_out}, 16'd1);

      // R6 gate suspends counting in mode 0
      wr(2'd3, 8'h30);
      wr(2'd0, 8'd32); wr(2'd0, 8'd0);
      tick();
      gate_in = 1'b0;
      tickn(5);
      rd16(v);
      check("R6 count held with gate low", v, 16'd32);
      gate_in = 1'b1;
      tickn(2);
      rd16(v);
      check("R6 count resumes with gate high", v, 16'd30);

      // R8 rate generator, n=4 and encoding 110 with n=3
      wr(2'd3, 8'h34);
      wr(2'd0, 8'd4); wr(2'd0, 8'd0);
      tick();
      check("R8 out high after load", {15'd0, tmr_out}, 16'd1);
      for (int k = 1; k <= 8; k++) begin
         tick();
         check($sformatf("R8 n=4 tick %0d", k), {15'd0, tmr_out}, {15'd0, exp_rate(k, 4)});
      end
      wr(2'd3, 8'h3C);
      wr(2'd0, 8'd3); wr(2'd0, 8'd0);
      tick();
      for (int k = 1; k <= 6; k++) begin
         tick();
         check($sformatf("R2 R8 mode x10 n=3 tick %0d", k), {15'd0, tmr_out}, {15'd0, exp_rate(k, 3)});
      end

      // R9 square wave, odd, even, and encoding 111
      wr(2'd3, 8'h36);
      wr(2'd0, 8'd5); wr(2'd0, 8'd0);
      tick();
      for (int k = 1; k <= 10; k++) begin
         tick();
         check($sformatf("R9 n=5 tick %0d", k), {15'd0, tmr_out}, {15'd0, exp_square(k, 5)});
      end
      wr(2'd3, 8'h36);
      wr(2'd0, 8'd4); wr(2'd0, 8'd0);
      tick();
      for (int k = 1; k <= 8; k++) begin
         tick();
         check($sformatf("R9 n=4 tick %0d", k), {15'd0, tmr_out}, {15'd0, exp_square(k, 4)});
      end
      wr(2'd3, 8'h3E);
      wr(2'd0, 8'd6); wr(2'd0, 8'd0);
      tick();
      for (int k = 1; k <= 12; k++) begin
         tick();
         check($sformatf("R2 R9 mode x11 n=6 tick %0d", k), {15'd0, tmr_out}, {15'd0, exp_square(k, 6)});
      end

      // R10 software strobe, n=3
      wr(2'd3, 8'h38);
      check("R2 mode4 out high after control", {15'd0, tmr_out}, 16'd1);
      wr(2'd0, 8'd3); wr(2'd0, 8'd0);
      tick();
      tickn(2);
      check("R10 out high before strobe", {15'd0, tmr_out}, 16'd1);
      tick();
      check("R10 strobe low", {15'd0, tmr_out}, 16'd0);
      tick();
      check("R10 strobe one tick", {15'd0, tmr_out}, 16'd1);
      tickn(6);
      check("R10 no auto reload", {15'd0, tmr_out}, 16'd1);

      // R1 foreign control words and counter addresses ignored
      wr(2'd3, 8'h70);
      check("R1 other channel control ignored", {15'd0, tmr_out}, 16'd1);
      wr(2'd3, 8'hF0);
      check("R1 read-back code ignored", {15'd0, tmr_out}, 16'd1);
      wr(2'd1, 8'h55); wr(2'd1, 8'h66);
      tick();
      rd16(v);
      check("R1 write to other counter ignored", v, 16'h0000);

      // R7 one-shot, n=3, with retrigger
      gate_in = 1'b0;
      wr(2'd3, 8'h32);
      check("R2 mode1 out high after control", {15'd0, tmr_out}, 16'd1);
      wr(2'd0, 8'd3); wr(2'd0, 8'd0);
      tickn(3);
      check("R7 no start without gate edge", {15'd0, tmr_out}, 16'd1);
      gate_pulse();
      tick();
      check("R7 out low on trigger", {15'd0, tmr_out}, 16'd0);
      tickn(2);
      check("R7 out low during interval", {15'd0, tmr_out}, 16'd0);
      tick();
      check("R7 out high after n", {15'd0, tmr_out}, 16'd1);
      gate_pulse();
      tick();
      tickn(2);
      gate_pulse();
      tick();
      tickn(2);
      check("R7 retrigger extends low", {15'd0, tmr_out}, 16'd0);
      tick();
      check("R7 out high after retriggered n", {15'd0, tmr_out}, 16'd1);

      // R11 gate-started strobe, n=2
      gate_in = 1'b0;
      wr(2'd3, 8'h3A);
      check("R2 mode5 out low after control", {15'd0, tmr_out}, 16'd0);
      wr(2'd0, 8'd2); wr(2'd0, 8'd0);
      tickn(3);
      check("R11 out low before trigger", {15'd0, tmr_out}, 16'd0);
      gate_pulse();
      tick();
      check("R11 out high on trigger", {15'd0, tmr_out}, 16'd1);
      tick();
      check("R11 out high mid count", {15'd0, tmr_out}, 16'd1);
      tick();
      check("R11 strobe low", {15'd0, tmr_out}, 16'd0);
      tick();
      check("R11 strobe ends", {15'd0, tmr_out}, 16'd1);

      // R3 single-byte access orders
      gate_in = 1'b0;
      wr(2'd3, 8'h10);
      wr(2'd0, 8'h7B);
      tick();
      rd(2'd0, b);
      check("R3 low-only load", {8'd0, b}, 16'h007B);
      rd(2'd0, b);
      check("R4 low-only read repeats low", {8'd0, b}, 16'h007B);
      wr(2'd3, 8'h20);
      wr(2'd0, 8'h12);
      tick();
      rd(2'd0, b);
      check("R3 high-only load", {8'd0, b}, 16'h0012);
      gate_in = 1'b1;
      tick();
      gate_in = 1'b0;
      rd(2'd0, b);
      check("R3 high-only clears low byte", {8'd0, b}, 16'h0011);

      // R3 first byte alone does not load
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h34);
      tick();
      rd16(v);
      check("R3 half-written count not loaded", v, 16'h11FF);
      wr(2'd0, 8'h12);
      tick();
      rd16(v);
      check("R3 full count loaded on tick", v, 16'h1234);

      // R4 latch command
      gate_in = 1'b1;
      tickn(3);
      wr(2'd3, 8'h00);
      tickn(2);
      rd(2'd0, b);
      check("R4 latched low byte", {8'd0, b}, 16'h0031);
      wr(2'd3, 8'h00);
      tick();
      rd(2'd0, b);
      check("R4 latched high byte", {8'd0, b}, 16'h0012);
      rd16(v);
      check("R4 live after latch released", v, 16'h122E);

      // random loads, gate-held and counted, live or latched reads
      for (int it = 0; it < 40; it++) begin
         logic [15:0] val, expv;
         int k, j;
         gate_in = 1'b0;
         wr(2'd3, 8'h30);
         val = 16'($urandom_range(65535, 6));
         wr(2'd0, val[7:0]); wr(2'd0, val[15:8]);
         tick();
         k = $urandom_range(3, 0);
         tickn(k);
         j = $urandom_range(5, 0);
         gate_in = 1'b1;
         tickn(j);
         gate_in = 1'b0;
         expv = val - 16'(j);
         if ($urandom_range(1, 0) == 1) begin
            wr(2'd3, 8'h00);
            gate_in = 1'b1;
            tickn(2);
            gate_in = 1'b0;
            rd16(v);
            check($sformatf("R4 R6 random latched read %0d", it), v, expv);
         end else begin
            rd16(v);
            check($sformatf("R3 R6 random live read %0d", it), v, expv);
         end
         check($sformatf("R5 random out low %0d", it), {15'd0, tmr_out}, 16'd0);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule